// File: doc/BRIEF.md
# Indirect Masked Memory Access Port

This block fronts a small array of 64-bit words, each with its own validity flag. Software reaches the array only through a 32-bit data bus and an internal address pointer. A decoded control instruction asks for a read or a write at the word the pointer names. A half-select input decides whether the low or the high 32 bits of that word move on the bus. After every accepted access the pointer steps up or down by one, as the instruction says. The pointer wraps at the array depth.

A write can be restricted bit by bit through one of seven loadable protect masks, chosen by a 3-bit field of the instruction. A set mask bit keeps the stored bit, and a clear mask bit lets the bus bit through. Field value zero selects a permanently clear mask, so nothing is protected. Each write also sets the word's validity flag from an active-low input. Each read returns the flag on an active-low output one cycle later, together with the data. The pointer and the masks are loaded through dedicated load ports.

The read path is a two-state machine. `ST_IDLE` moves to `ST_RD_OUT` on an accepted read, and otherwise stays in `ST_IDLE`. `ST_RD_OUT` stays in `ST_RD_OUT` on another accepted read (back-to-back reads), and otherwise returns to `ST_IDLE`. The machine is in `ST_RD_OUT` exactly in the cycles that present read data.

Top module: `ima_port`

## Requirements
- R1: An access is accepted only when `cmd_valid_i` is 1, `addr_strobe_i` is 1 and `instr_i[5:0]` is 6'b100110 or 6'b100111. Any other combination writes nothing, reads nothing and leaves the pointer unchanged.
- R2: In an accepted access, `wr_n_i` = 0 requests a write and `wr_n_i` = 1 requests a read.
- R3: `half_hi_i` = 0 selects word bits 31:0 and `half_hi_i` = 1 selects bits 63:32, for reads and for writes. A write leaves the other half of the word untouched.
- R4: A write stores validity = NOT `vld_n_i`, so 0 marks the word valid and 1 marks it empty. A read returns the stored flag on `vld_n_o` (0 = valid). After reset every word holds zero data and is empty.
- R5: `instr_i[8:6]` selects a protect mask for a write. The mask half that is used matches the selected word half. A mask bit of 1 keeps the stored bit, a mask bit of 0 lets the bus bit through, and code 0 protects nothing.
- R6: After each accepted access the pointer increments when `instr_i[0]` = 0 and decrements when `instr_i[0]` = 1.
- R7: The pointer wraps modulo DEPTH: DEPTH-1 increments to 0, and 0 decrements to DEPTH-1.
- R8: Read data, with `rd_valid_o` = 1 and `data_oe_o` = 1, appears in the cycle after the accepted read. In every other cycle `rd_valid_o` = 0, `data_oe_o` = 0, `data_o` = 0 and `vld_n_o` = 1.
- R9: `ld_addr_i` = 1 loads `ld_addr_val_i` into the pointer, taking priority over the post-step. An access in the same cycle uses the old pointer.
- R10: `ld_mask_i` = 1 loads `ld_mask_val_i` into mask `ld_mask_sel_i` for codes 1 to 7. Code 0 ignores the load, and its mask stays all zero. A write in the same cycle uses the old mask.
- R11: The read machine goes `ST_IDLE` to `ST_RD_OUT` on an accepted read, stays in `ST_RD_OUT` on back-to-back reads, and returns to `ST_IDLE` otherwise. Back-to-back reads give data in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 9 | [5:0] opcode, [8:6] mask select |
| wr_n_i | input | 1 | 0 = write, 1 = read |
| addr_strobe_i | input | 1 | Must be 1 for an indirect access |
| half_hi_i | input | 1 | 0 = bits 31:0, 1 = bits 63:32 |
| vld_n_i | input | 1 | Validity written: 0 valid, 1 empty |
| data_i | input | BUS_W | Write data |
| ld_addr_i | input | 1 | Load pointer |
| ld_addr_val_i | input | AW | Pointer load value (below DEPTH) |
| ld_mask_i | input | 1 | Load a protect mask |
| ld_mask_sel_i | input | 3 | Mask to load (0 ignored) |
| ld_mask_val_i | input | 2*BUS_W | Mask load value |
| data_o | output | BUS_W | Read data, zero when not valid |
| data_oe_o | output | 1 | Bus drive enable, read cycles only |
| rd_valid_o | output | 1 | Read data valid |
| vld_n_o | output | 1 | Validity of the word read (0 valid) |

## Verification
The bench tries writes with protect code 0, with a loaded mask whose halves differ, and with a mask code whose load was refused. These show whether protection polarity and half alignment are right, and whether code 0 is truly fixed at zero. Increment and decrement runs across both array ends separate a correct wrap from a saturating or unwrapped pointer. Near-miss opcodes, a low address strobe and a dropped command valid, each followed by readback, show that only exact instructions act. A pointer load in the same cycle as an access, and back-to-back reads, pin down load priority and the state machine's stay-in-read transition.

// File: rtl/ima_pkg.sv
package ima_pkg;
    localparam int MSEL_W = 3;
    localparam int OPC_W  = 6;
    localparam logic [OPC_W-2:0] OPC_INDIRECT = 5'b10011;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RD_OUT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/ima_decode.sv
module ima_decode
    import ima_pkg::*;
(
    input  logic                    cmd_valid_i,
    input  logic [OPC_W+MSEL_W-1:0] instr_i,
    input  logic                    wr_n_i,
    input  logic                    addr_strobe_i,
    output logic                    acc_o,
    output logic                    wr_o,
    output logic                    rd_o,
    output logic                    dec_o,
    output logic [MSEL_W-1:0]       msel_o
);
    always_comb begin
        acc_o  = cmd_valid_i && addr_strobe_i && (instr_i[OPC_W-1:1] == OPC_INDIRECT);
        wr_o   = acc_o && !wr_n_i;
        rd_o   = acc_o && wr_n_i;
        dec_o  = instr_i[0];
        msel_o = instr_i[OPC_W+MSEL_W-1:OPC_W];
    end
endmodule

// File: rtl/ima_mask_bank.sv
module ima_mask_bank
    import ima_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ld_i,
    input  logic [MSEL_W-1:0] ld_sel_i,
    input  logic [WORD_W-1:0] ld_val_i,
    input  logic [MSEL_W-1:0] rd_sel_i,
    output logic [WORD_W-1:0] mask_o
);
    localparam int NMASK = 1 << MSEL_W;

    logic [WORD_W-1:0] bank_w [NMASK];

    for (genvar i = 0; i < NMASK; i++) begin : g_mask
        if (i == 0) begin : g_zero
            assign bank_w[i] = '0;
        end else begin : g_reg
            logic [WORD_W-1:0] msk_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    msk_q <= '0;
                end else if (ld_i && (ld_sel_i == MSEL_W'(i))) begin
                    msk_q <= ld_val_i;
                end
            end
            assign bank_w[i] = msk_q;
        end
    end

    assign mask_o = bank_w[rd_sel_i];
endmodule

// File: rtl/ima_array.sv
module ima_array #(
    parameter int DEPTH = 16,
    parameter int BUS_W = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [BUS_W-1:0] prot_i,
    input  logic             vld_n_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             rvld_n_o
);
    logic [BUS_W-1:0] lo_w  [DEPTH];
    logic [BUS_W-1:0] hi_w  [DEPTH];
    logic             vld_w [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [BUS_W-1:0] lo_q, hi_q;
        logic             vld_q;
        logic             hit;
        assign hit = we_i && (addr_i == AW'(w));
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lo_q  <= '0;
                hi_q  <= '0;
                vld_q <= 1'b0;
            end else if (hit) begin
                if (hi_i) begin
                    hi_q <= (hi_q & prot_i) | (wdata_i & ~prot_i);
                end else begin
                    lo_q <= (lo_q & prot_i) | (wdata_i & ~prot_i);
                end
                vld_q <= !vld_n_i;
            end
        end
        assign lo_w[w]  = lo_q;
        assign hi_w[w]  = hi_q;
        assign vld_w[w] = vld_q;
    end

    assign rdata_o  = hi_i ? hi_w[addr_i] : lo_w[addr_i];
    assign rvld_n_o = !vld_w[addr_i];
endmodule

// File: rtl/ima_ctrl.sv
module ima_ctrl
    import ima_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BUS_W = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_i,
    input  logic             rd_i,
    input  logic             dec_i,
    input  logic             ld_i,
    input  logic [AW-1:0]    ld_val_i,
    input  logic [BUS_W-1:0] rdata_i,
    input  logic             rvld_n_i,
    output logic [AW-1:0]    addr_o,
    output logic [BUS_W-1:0] data_o,
    output logic             oe_o,
    output logic             rd_valid_o,
    output logic             vld_n_o
);
    localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

    rd_state_e        st_q, st_d;
    logic [AW-1:0]    addr_q;
    logic [BUS_W-1:0] dat_q;
    logic             vn_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (rd_i)  st_d = ST_RD_OUT;
            ST_RD_OUT: if (!rd_i) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and read capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_IDLE;
            dat_q <= '0;
            vn_q  <= 1'b1;
        end else begin
            st_q <= st_d;
            if (rd_i) begin
                dat_q <= rdata_i;
                vn_q  <= rvld_n_i;
            end
        end
    end

    // outputs
    always_comb begin
        rd_valid_o = (st_q == ST_RD_OUT);
        oe_o       = (st_q == ST_RD_OUT);
        data_o     = (st_q == ST_RD_OUT) ? dat_q : '0;
        vld_n_o    = (st_q == ST_RD_OUT) ? vn_q : 1'b1;
    end

    // address pointer with wrap
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
        end else if (ld_i) begin
            addr_q <= ld_val_i;
        end else if (acc_i) begin
            if (dec_i) begin
                addr_q <= (addr_q == '0) ? ADDR_LAST : addr_q - 1'b1;
            end else begin
                addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
            end
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/ima_port.sv
module ima_port
    import ima_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BUS_W = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          cmd_valid_i,
    input  logic [OPC_W+MSEL_W-1:0]       instr_i,
    input  logic                          wr_n_i,
    input  logic                          addr_strobe_i,
    input  logic                          half_hi_i,
    input  logic                          vld_n_i,
    input  logic [BUS_W-1:0]              data_i,
    input  logic                          ld_addr_i,
    input  logic [$clog2(DEPTH)-1:0]      ld_addr_val_i,
    input  logic                          ld_mask_i,
    input  logic [MSEL_W-1:0]             ld_mask_sel_i,
    input  logic [2*BUS_W-1:0]            ld_mask_val_i,
    output logic [BUS_W-1:0]              data_o,
    output logic                          data_oe_o,
    output logic                          rd_valid_o,
    output logic                          vld_n_o
);
    localparam int AW     = $clog2(DEPTH);
    localparam int WORD_W = 2 * BUS_W;

    logic              acc, wr, rd, dec;
    logic [MSEL_W-1:0] msel;
    logic [WORD_W-1:0] mask_full;
    logic [BUS_W-1:0]  prot_half;
    logic [BUS_W-1:0]  rdata;
    logic              rvld_n;
    logic [AW-1:0]     addr_q;

    ima_decode u_dec (
        .cmd_valid_i   (cmd_valid_i),
        .instr_i       (instr_i),
        .wr_n_i        (wr_n_i),
        .addr_strobe_i (addr_strobe_i),
        .acc_o         (acc),
        .wr_o          (wr),
        .rd_o          (rd),
        .dec_o         (dec),
        .msel_o        (msel)
    );

    ima_mask_bank #(.WORD_W(WORD_W)) u_masks (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (ld_mask_i),
        .ld_sel_i (ld_mask_sel_i),
        .ld_val_i (ld_mask_val_i),
        .rd_sel_i (msel),
        .mask_o   (mask_full)
    );

    assign prot_half = half_hi_i ? mask_full[WORD_W-1:BUS_W] : mask_full[BUS_W-1:0];

    ima_array #(.DEPTH(DEPTH), .BUS_W(BUS_W), .AW(AW)) u_array (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (wr),
        .addr_i   (addr_q),
        .hi_i     (half_hi_i),
        .wdata_i  (data_i),
        .prot_i   (prot_half),
        .vld_n_i  (vld_n_i),
        .rdata_o  (rdata),
        .rvld_n_o (rvld_n)
    );

    ima_ctrl #(.DEPTH(DEPTH), .BUS_W(BUS_W), .AW(AW)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acc_i      (acc),
        .rd_i       (rd),
        .dec_i      (dec),
        .ld_i       (ld_addr_i),
        .ld_val_i   (ld_addr_val_i),
        .rdata_i    (rdata),
        .rvld_n_i   (rvld_n),
        .addr_o     (addr_q),
        .data_o     (data_o),
        .oe_o       (data_oe_o),
        .rd_valid_o (rd_valid_o),
        .vld_n_o    (vld_n_o)
    );
endmodule

// File: rtl/ima_port_chk.sv
module ima_port_chk #(
    parameter int DEPTH = 16,
    parameter int BUS_W = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cmd_valid_i,
    input logic [5:0]       opc_i,
    input logic             wr_n_i,
    input logic             addr_strobe_i,
    input logic             ld_addr_i,
    input logic [AW-1:0]    ld_addr_val_i,
    input logic [BUS_W-1:0] data_o,
    input logic             data_oe_o,
    input logic             rd_valid_o,
    input logic             vld_n_o,
    input logic [AW-1:0]    addr_q
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic take, take_rd;
    assign take    = cmd_valid_i && addr_strobe_i && (opc_i[5:1] == 5'b10011);
    assign take_rd = take && wr_n_i;

    // R8: data follows an accepted read by one cycle
    assert_rd_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_rd |=> (rd_valid_o && data_oe_o));
    assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_rd |=> (!rd_valid_o && !data_oe_o));
    assert_quiet_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_o |-> (data_o == '0 && vld_n_o));

    // R1: rejected commands leave the pointer alone
    assert_hold_ptr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!take && !ld_addr_i) |=> $stable(addr_q));

    // R6 / R7: post-step with wrap
    assert_inc_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && !ld_addr_i && !opc_i[0]) |=>
        (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1)));
    assert_dec_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && !ld_addr_i && opc_i[0]) |=>
        (addr_q == (($past(addr_q) == '0) ? LAST : $past(addr_q) - 1'b1)));

    // R9: load wins
    assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_addr_i |=> (addr_q == $past(ld_addr_val_i)));
endmodule

bind ima_port ima_port_chk #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .opc_i         (instr_i[5:0]),
    .wr_n_i        (wr_n_i),
    .addr_strobe_i (addr_strobe_i),
    .ld_addr_i     (ld_addr_i),
    .ld_addr_val_i (ld_addr_val_i),
    .data_o        (data_o),
    .data_oe_o     (data_oe_o),
    .rd_valid_o    (rd_valid_o),
    .vld_n_o       (vld_n_o),
    .addr_q        (addr_q)
);

// File: tb/ima_port_tb.sv
`timescale 1ns/1ps
module ima_port_tb;
    localparam int DEPTH = 16;
    localparam int BUS_W = 32;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             cmd_valid;
    logic [8:0]       instr;
    logic             wr_n, strobe, hi, vn;
    logic [BUS_W-1:0] din;
    logic             ld_addr;
    logic [AW-1:0]    ld_aval;
    logic             ld_mask;
    logic [2:0]       ld_msel;
    logic [63:0]      ld_mval;
    logic [BUS_W-1:0] data_o;
    logic             data_oe_o, rd_valid_o, vld_n_o;

    always #4 clk = ~clk;

    ima_port #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .instr_i(instr),
        .wr_n_i(wr_n), .addr_strobe_i(strobe), .half_hi_i(hi), .vld_n_i(vn),
        .data_i(din), .ld_addr_i(ld_addr), .ld_addr_val_i(ld_aval),
        .ld_mask_i(ld_mask), .ld_mask_sel_i(ld_msel), .ld_mask_val_i(ld_mval),
        .data_o(data_o), .data_oe_o(data_oe_o), .rd_valid_o(rd_valid_o), .vld_n_o(vld_n_o)
    );

    // behavioural reference state
    logic [31:0] m_lo [DEPTH];
    logic [31:0] m_hi [DEPTH];
    bit          m_ok [DEPTH];
    logic [63:0] m_mask [8];
    int          m_ptr;
    int          vectors = 0;
    int          miscmp  = 0;
    bit          done    = 1'b0;

    task automatic clr();
        cmd_valid = 0; instr = '0; wr_n = 1; strobe = 1; hi = 0; vn = 1; din = '0;
        ld_addr = 0; ld_aval = '0; ld_mask = 0; ld_msel = '0; ld_mval = '0;
    endtask

    task automatic tick(input string tag);
        bit          e_rv = 0;
        logic [31:0] e_d  = '0;
        bit          e_vn = 1;
        bit          take;
        logic [31:0] prot;
        int          a = m_ptr;
        take = cmd_valid && strobe && (instr[5:0] == 6'b100110 || instr[5:0] == 6'b100111);
        if (take && !wr_n) begin
            prot = hi ? m_mask[instr[8:6]][63:32] : m_mask[instr[8:6]][31:0];
            if (hi) m_hi[a] = (m_hi[a] & prot) | (din & ~prot);
            else    m_lo[a] = (m_lo[a] & prot) | (din & ~prot);
            m_ok[a] = !vn;
        end else if (take) begin
            e_rv = 1;
            e_d  = hi ? m_hi[a] : m_lo[a];
            e_vn = !m_ok[a];
        end
        if (ld_addr) m_ptr = int'(ld_aval);
        else if (take) m_ptr = instr[0] ? (a + DEPTH - 1) % DEPTH : (a + 1) % DEPTH;
        if (ld_mask && ld_msel != 3'd0) m_mask[ld_msel] = ld_mval;
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (rd_valid_o !== e_rv || data_oe_o !== e_rv || data_o !== e_d || vld_n_o !== e_vn) begin
            miscmp++;
            $display("FAIL %s: rv=%0b oe=%0b d=%h vn=%0b, expected rv=%0b oe=%0b d=%h vn=%0b",
                     tag, rd_valid_o, data_oe_o, data_o, vld_n_o, e_rv, e_rv, e_d, e_vn);
        end
    endtask

    task automatic acc(input string tag, input bit wr, input bit dec, input logic [2:0] ms,
                       input bit h, input bit v_n, input logic [31:0] d);
        clr();
        cmd_valid = 1; instr = {ms, 5'b10011, dec}; wr_n = !wr; hi = h; vn = v_n; din = d;
        tick(tag);
    endtask

    task automatic setptr(input string tag, input int a);
        clr(); ld_addr = 1; ld_aval = AW'(a); tick(tag);
    endtask

    task automatic setmask(input string tag, input logic [2:0] s, input logic [63:0] v);
        clr(); ld_mask = 1; ld_msel = s; ld_mval = v; tick(tag);
    endtask

    task automatic idle(input string tag);
        clr(); tick(tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_ok[i] = 0; end
        for (int i = 0; i < 8; i++) m_mask[i] = '0;
        m_ptr = 0;
        clr();
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // reset state: quiet bus, empty zero words (R4, R8)
        idle("R8");
        acc("R4", 0, 0, 3'd0, 0, 1, '0);
        acc("R4", 0, 0, 3'd0, 1, 1, '0);
        // unmasked writes to both halves, readback (R2, R3, R4, R6)
        setptr("R9", 3);
        acc("R2", 1, 0, 3'd0, 0, 0, 32'hA5A5_0001);
        acc("R3", 1, 1, 3'd0, 1, 0, 32'h1234_5678);
        acc("R3", 1, 0, 3'd0, 1, 1, 32'hDEAD_BEEF);
        setptr("R9", 3);
        acc("R3", 0, 0, 3'd0, 0, 0, '0);
        acc("R4", 0, 0, 3'd0, 1, 0, '0);
        acc("R6", 0, 1, 3'd0, 0, 0, '0);
        acc("R3", 0, 1, 3'd0, 1, 0, '0);
        // back-to-back reads then idle (R11)
        setptr("R9", 3);
        acc("R11", 0, 0, 3'd0, 0, 0, '0);
        acc("R11", 0, 0, 3'd0, 1, 0, '0);
        acc("R11", 0, 0, 3'd0, 1, 0, '0);
        idle("R11");
        // wrap at both ends (R7)
        setptr("R9", 0);
        acc("R7", 1, 1, 3'd0, 0, 0, 32'h0000_00AA);
        acc("R7", 1, 0, 3'd0, 0, 0, 32'h0000_00BB);
        acc("R7", 0, 1, 3'd0, 0, 0, '0);
        acc("R7", 0, 1, 3'd0, 0, 0, '0);
        acc("R7", 0, 0, 3'd0, 0, 0, '0);
        // masked writes with half-specific masks (R5)
        setmask("R10", 3'd2, 64'h0000_FFFF_FF00_FF00);
        setptr("R9", 8);
        acc("R5", 1, 0, 3'd0, 0, 0, 32'h1111_1111);
        acc("R5", 1, 0, 3'd0, 1, 0, 32'h2222_2222);
        setptr("R9", 8);
        acc("R5", 1, 0, 3'd2, 0, 0, 32'hFFFF_FFFF);
        setptr("R9", 8);
        acc("R5", 1, 0, 3'd2, 1, 0, 32'hFFFF_FFFF);
        setptr("R9", 8);
        acc("R5", 0, 0, 3'd0, 0, 0, '0);
        setptr("R9", 8);
        acc("R5", 0, 0, 3'd0, 1, 0, '0);
        // load to mask code 0 ignored (R10)
        setmask("R10", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        setptr("R9", 10);
        acc("R10", 1, 0, 3'd0, 0, 0, 32'hCAFE_F00D);
        setptr("R9", 10);
        acc("R10", 0, 0, 3'd0, 0, 0, '0);
        // mask load and write in same cycle: write uses old mask (R10)
        setmask("R10", 3'd5, 64'hFFFF_FFFF_0000_0000);
        setptr("R9", 11);
        clr(); cmd_valid = 1; instr = {3'd5, 6'b100110}; wr_n = 0; hi = 1; vn = 0;
        din = 32'h7777_7777; ld_mask = 1; ld_msel = 3'd5; ld_mval = '0; tick("R10");
        setptr("R9", 11);
        acc("R10", 0, 0, 3'd0, 1, 0, '0);
        // rejected commands (R1)
        setptr("R9", 12);
        clr(); cmd_valid = 1; instr = {3'd0, 6'b100010}; wr_n = 0; din = 32'h0BAD_0001; vn = 0; tick("R1");
        clr(); cmd_valid = 1; instr = {3'd0, 6'b000110}; wr_n = 1; tick("R1");
        clr(); cmd_valid = 1; instr = {3'd0, 6'b100110}; wr_n = 0; strobe = 0; din = 32'h0BAD_0002; vn = 0; tick("R1");
        clr(); cmd_valid = 0; instr = {3'd0, 6'b100110}; wr_n = 0; din = 32'h0BAD_0003; vn = 0; tick("R1");
        acc("R1", 0, 0, 3'd0, 0, 0, '0);
        // pointer load wins over post-step; access uses old pointer (R9)
        setptr("R9", 4);
        clr(); cmd_valid = 1; instr = {3'd0, 6'b100110}; wr_n = 1; ld_addr = 1; ld_aval = AW'(9); tick("R9");
        acc("R9", 0, 0, 3'd0, 0, 0, '0);
        idle("R8");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: expected=finished actual=hung");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end
endmodule